// File: doc/BRIEF.md
# Single-Channel Word DMA Mover

This block copies a block of 32-bit words from one address range to another without processor involvement. Software sets it up through a small register port: a source address, a destination address, a mode word and a byte length. Writing the length starts the copy. From then on the block works as a bus master on two independent channels. The read channel fetches words from the source into an internal FIFO. The write channel drains the FIFO to the destination. The two channels run at the same time, and each is limited only by how full the FIFO is.

Each side can step its address by four bytes per word, or it can stay on one fixed address. The fixed mode suits a memory-mapped peripheral queue, which accepts or supplies an endless stream of words at a single location. A status word reports whether a copy is running, whether it has completed and whether a bus error stopped it. An interrupt line can be enabled to signal completion or an error.

Top module: `xferEngine`

## Requirements
- R1: After reset, busy, done and error are 0, irq is 0, rdReq and wrReq are 0, and every register reads back 0.
- R2: Register word index on regAddr: 0 = source address, 1 = destination address, 2 = mode (bit 0 source step, bit 1 destination step, bit 2 interrupt enable), 3 = byte length (bits 1:0 read back 0), 4 = status (bit 0 busy, bit 1 done, bit 2 error). regRdata reflects regAddr combinationally.
- R3: Writing index 3 while idle with any of bits LEN_W-1:2 set starts a copy of that many bytes divided by 4. Busy reads 1 from the next cycle, and done and error are cleared. A value whose only set bits are bits 1:0 starts nothing.
- R4: Read k (counting from 0) targets source + 4k when the source step bit is 1, and the source address for every read when it is 0. rdAddr stays stable while rdReq waits for rdGnt.
- R5: Write k targets destination + 4k when the destination step bit is 1, and the destination address for every write when it is 0. wrAddr stays stable while wrReq waits for wrGnt.
- R6: A copy performs exactly length/4 reads and length/4 writes, and write k carries the data returned by read k.
- R7: At most one read is outstanding at a time. A read is requested only while the FIFO has a free entry, so the number of words read but not yet granted for writing never exceeds FIFO_DEPTH. With a slow destination that number reaches FIFO_DEPTH.
- R8: Done rises, and busy falls, only on the acknowledge of the last write.
- R9: Writing status with bit 1 set clears done. Writing status with bit 2 set clears error.
- R10: A read response with rdErr, or a write acknowledge with wrErr, sets error and clears busy without setting done. No further requests are made.
- R11: While busy, writes to indices 0 to 3 change neither the registers nor the running copy.
- R12: irq is 1 exactly while the interrupt-enable bit is 1 and done or error is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data for regAddr |
| rdReq | output | 1 | Read request, held until granted |
| rdAddr | output | ADDR_W | Read address |
| rdGnt | input | 1 | Read request accepted |
| rdValid | input | 1 | Read data returned |
| rdData | input | DATA_W | Read data |
| rdErr | input | 1 | Read response is an error (with rdValid) |
| wrReq | output | 1 | Write request, held until granted |
| wrAddr | output | ADDR_W | Write address |
| wrData | output | DATA_W | Write data |
| wrGnt | input | 1 | Write request accepted |
| wrAck | input | 1 | Write completed |
| wrErr | input | 1 | Write completion is an error (with wrAck) |
| irq | output | 1 | Interrupt |

## Verification
Copies are run with all four combinations of the step bits. A stepping source is told apart from a fixed one by the address of every read, and the same holds for the destination with every write. Because each returned word is derived from both its address and its position in the sequence, reordered or dropped data shows up in the written values. A slow destination against a fast source fills the FIFO to its depth, which separates a correct vacancy limit from one that stalls early or overruns. A fast destination keeps both channels busy in the same cycles. Errors injected partway into reads and writes, and register writes issued during a copy, exercise the abort and write-protection paths, and randomized lengths, addresses and grant latencies mix these cases.

// File: rtl/xferPkg.sv
package xferPkg;

  // register word indices on the slave port
  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_MODE = 3'd2;
  localparam logic [2:0] REG_LEN  = 3'd3;
  localparam logic [2:0] REG_STAT = 3'd4;

  // mode bits
  localparam int MODE_SRC_STEP = 0;
  localparam int MODE_DST_STEP = 1;
  localparam int MODE_IRQ_EN   = 2;
  localparam int MODE_W        = 3;

  // status bits
  localparam int STAT_BUSY = 0;
  localparam int STAT_DONE = 1;
  localparam int STAT_ERR  = 2;

  localparam int WORD_BYTES = 4;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_REQ,
    PH_WAIT
  } phase_t;

  // control -> datapath strobes
  typedef struct packed {
    logic start;    // latch pointers from registers
    logic push;     // read word accepted into FIFO
    logic srcStep;  // advance source pointer
    logic pop;      // head word granted to write channel
    logic dstStep;  // advance destination pointer
    logic flush;    // empty the FIFO
  } xferStrobes_t;

endpackage

// File: rtl/xferFifo.sv
module xferFifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           push,
  input  logic                           pop,
  input  logic                           flush,
  input  logic [WIDTH-1:0]               pushData,
  output logic [WIDTH-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  generate
    if (DEPTH == 1) begin : g_single
      logic [WIDTH-1:0] slot;
      logic             full;

      always_ff @(posedge clk) begin
        if (!rstN)                 full <= 1'b0;
        else if (flush)            full <= 1'b0;
        else if (push && !full)    full <= 1'b1;
        else if (pop && full)      full <= 1'b0;
      end

      always_ff @(posedge clk) begin
        if (push && !full) slot <= pushData;
      end

      assign head  = slot;
      assign count = CNT_W'(full);
    end else begin : g_ring
      logic [WIDTH-1:0] mem [DEPTH];
      logic [PTR_W-1:0] wrPtr, rdPtr;
      logic [CNT_W-1:0] cnt;
      logic             doPush, doPop;

      function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
      endfunction

      assign doPush = push && (cnt < CNT_W'(DEPTH));
      assign doPop  = pop && (cnt != '0);

      always_ff @(posedge clk) begin
        if (!rstN || flush) begin
          wrPtr <= '0;
          rdPtr <= '0;
          cnt   <= '0;
        end else begin
          if (doPush) wrPtr <= bump(wrPtr);
          if (doPop)  rdPtr <= bump(rdPtr);
          if (doPush && !doPop)      cnt <= cnt + CNT_W'(1);
          else if (doPop && !doPush) cnt <= cnt - CNT_W'(1);
        end
      end

      always_ff @(posedge clk) begin
        if (doPush) mem[wrPtr] <= pushData;
      end

      assign head  = mem[rdPtr];
      assign count = cnt;
    end
  endgenerate

endmodule

// File: rtl/xferCtrl.sv
module xferCtrl
  import xferPkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               regWe,
  input  logic [2:0]                         regAddr,
  input  logic [DATA_W-1:0]                  regWdata,
  input  logic                               rdGnt,
  input  logic                               rdValid,
  input  logic                               rdErr,
  input  logic                               wrGnt,
  input  logic                               wrAck,
  input  logic                               wrErr,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0]    fifoCount,
  input  logic                               irqEn,
  output xferStrobes_t                       strobes,
  output logic                               rdReq,
  output logic                               wrReq,
  output logic                               busy,
  output logic                               done,
  output logic                               err,
  output logic                               irq
);
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int WORD_W = LEN_W - 2;

  phase_t            rdPh, wrPh;
  logic [WORD_W-1:0] rdLeft, wrLeft;
  logic [WORD_W-1:0] startWords;
  logic              startHit, statWrite;
  logic              rdResp, wrResp, abort;
  logic              unusedWdata;

  assign startWords = regWdata[LEN_W-1:2];
  assign startHit   = regWe && !busy && (regAddr == REG_LEN) && (startWords != '0);
  assign statWrite  = regWe && (regAddr == REG_STAT);
  assign unusedWdata = ^regWdata;

  assign rdResp = (rdPh == PH_WAIT) && rdValid;
  assign wrResp = (wrPh == PH_WAIT) && wrAck;
  assign abort  = (rdResp && rdErr) || (wrResp && wrErr);

  assign rdReq = (rdPh == PH_REQ);
  assign wrReq = (wrPh == PH_REQ);

  always_comb begin
    strobes         = '0;
    strobes.start   = startHit;
    strobes.flush   = startHit || abort;
    strobes.push    = rdResp && !rdErr && !abort;
    strobes.srcStep = rdResp && !rdErr && !abort;
    strobes.pop     = (wrPh == PH_REQ) && wrGnt && !abort;
    strobes.dstStep = wrResp && !wrErr && !abort;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      rdPh   <= PH_IDLE;
      wrPh   <= PH_IDLE;
      rdLeft <= '0;
      wrLeft <= '0;
    end else begin
      if (statWrite) begin
        if (regWdata[STAT_DONE]) done <= 1'b0;
        if (regWdata[STAT_ERR])  err  <= 1'b0;
      end
      if (startHit) begin
        busy   <= 1'b1;
        done   <= 1'b0;
        err    <= 1'b0;
        rdLeft <= startWords;
        wrLeft <= startWords;
        rdPh   <= PH_IDLE;
        wrPh   <= PH_IDLE;
      end else if (abort) begin
        busy <= 1'b0;
        err  <= 1'b1;
        rdPh <= PH_IDLE;
        wrPh <= PH_IDLE;
      end else if (busy) begin
        unique case (rdPh)
          PH_IDLE: if (rdLeft != '0 && fifoCount < CNT_W'(FIFO_DEPTH)) rdPh <= PH_REQ;
          PH_REQ:  if (rdGnt) rdPh <= PH_WAIT;
          PH_WAIT: if (rdValid) begin
                     rdPh   <= PH_IDLE;
                     rdLeft <= rdLeft - WORD_W'(1);
                   end
          default: rdPh <= PH_IDLE;
        endcase
        unique case (wrPh)
          PH_IDLE: if (wrLeft != '0 && fifoCount != '0) wrPh <= PH_REQ;
          PH_REQ:  if (wrGnt) wrPh <= PH_WAIT;
          PH_WAIT: if (wrAck) begin
                     wrPh   <= PH_IDLE;
                     wrLeft <= wrLeft - WORD_W'(1);
                     if (wrLeft == WORD_W'(1)) begin
                       busy <= 1'b0;
                       done <= 1'b1;
                     end
                   end
          default: wrPh <= PH_IDLE;
        endcase
      end
    end
  end

  assign irq = irqEn && (done || err);

endmodule

// File: rtl/xferPath.sv
module xferPath
  import xferPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               regWe,
  input  logic [2:0]                         regAddr,
  input  logic [DATA_W-1:0]                  regWdata,
  output logic [DATA_W-1:0]                  regRdata,
  input  logic                               busy,
  input  logic                               done,
  input  logic                               err,
  input  xferStrobes_t                       strobes,
  input  logic [DATA_W-1:0]                  rdData,
  output logic [ADDR_W-1:0]                  rdAddr,
  output logic [ADDR_W-1:0]                  wrAddr,
  output logic [DATA_W-1:0]                  wrData,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]    fifoCount,
  output logic                               irqEn
);
  logic [ADDR_W-1:0] srcReg, dstReg, srcPtr, dstPtr;
  logic [MODE_W-1:0] modeReg;
  logic [LEN_W-1:0]  lenReg;
  logic              cfgWe;

  assign cfgWe = regWe && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg  <= '0;
      dstReg  <= '0;
      modeReg <= '0;
      lenReg  <= '0;
    end else if (cfgWe) begin
      unique case (regAddr)
        REG_SRC:  srcReg  <= regWdata[ADDR_W-1:0];
        REG_DST:  dstReg  <= regWdata[ADDR_W-1:0];
        REG_MODE: modeReg <= regWdata[MODE_W-1:0];
        REG_LEN:  lenReg  <= {regWdata[LEN_W-1:2], 2'b00};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPtr <= '0;
      dstPtr <= '0;
    end else if (strobes.start) begin
      srcPtr <= srcReg;
      dstPtr <= dstReg;
    end else begin
      if (strobes.srcStep && modeReg[MODE_SRC_STEP]) srcPtr <= srcPtr + ADDR_W'(WORD_BYTES);
      if (strobes.dstStep && modeReg[MODE_DST_STEP]) dstPtr <= dstPtr + ADDR_W'(WORD_BYTES);
    end
  end

  always_comb begin
    unique case (regAddr)
      REG_SRC:  regRdata = DATA_W'(srcReg);
      REG_DST:  regRdata = DATA_W'(dstReg);
      REG_MODE: regRdata = DATA_W'(modeReg);
      REG_LEN:  regRdata = DATA_W'(lenReg);
      REG_STAT: regRdata = DATA_W'({err, done, busy});
      default:  regRdata = '0;
    endcase
  end

  xferFifo #(
    .DEPTH (FIFO_DEPTH),
    .WIDTH (DATA_W)
  ) fifo_i (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobes.push),
    .pop      (strobes.pop),
    .flush    (strobes.flush),
    .pushData (rdData),
    .head     (wrData),
    .count    (fifoCount)
  );

  assign rdAddr = srcPtr;
  assign wrAddr = dstPtr;
  assign irqEn  = modeReg[MODE_IRQ_EN];

endmodule

// File: rtl/xferEngine.sv
module xferEngine
  import xferPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdGnt,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  input  logic              rdErr,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  input  logic              wrGnt,
  input  logic              wrAck,
  input  logic              wrErr,
  output logic              irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  xferStrobes_t     strobes;
  logic             busy, done, err, irqEn;
  logic [CNT_W-1:0] fifoCount;

  xferCtrl #(
    .DATA_W     (DATA_W),
    .LEN_W      (LEN_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .rdGnt     (rdGnt),
    .rdValid   (rdValid),
    .rdErr     (rdErr),
    .wrGnt     (wrGnt),
    .wrAck     (wrAck),
    .wrErr     (wrErr),
    .fifoCount (fifoCount),
    .irqEn     (irqEn),
    .strobes   (strobes),
    .rdReq     (rdReq),
    .wrReq     (wrReq),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .irq       (irq)
  );

  xferPath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LEN_W      (LEN_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) path_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .strobes   (strobes),
    .rdData    (rdData),
    .rdAddr    (rdAddr),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .fifoCount (fifoCount),
    .irqEn     (irqEn)
  );

endmodule

// File: rtl/xferChecker.sv
module xferChecker #(
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [2:0]        regAddr,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdGnt,
  input logic              rdValid,
  input logic              rdErr,
  input logic              wrReq,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              wrGnt,
  input logic              wrAck,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              irq
);
  localparam int HW = $clog2(FIFO_DEPTH + 1) + 1;

  logic          rdOut;
  logic [HW-1:0] held;

  // track the one read in flight and the words between read return and write grant
  always_ff @(posedge clk) begin
    if (!rstN || !busy) begin
      rdOut <= 1'b0;
      held  <= '0;
    end else begin
      if (rdReq && rdGnt)  rdOut <= 1'b1;
      else if (rdValid)    rdOut <= 1'b0;
      held <= held + HW'(rdOut && rdValid && !rdErr) - HW'(wrReq && wrGnt);
    end
  end

  a_r7_single_read: assert property (@(posedge clk) disable iff (!rstN)
    rdOut |-> !rdReq);

  a_r7_fifo_bound: assert property (@(posedge clk) disable iff (!rstN)
    held <= HW'(FIFO_DEPTH));

  a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(wrAck));

  a_r3_start_from_len: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWe && regAddr == 3'd3));

  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (!rdReq && !wrReq));

  a_r12_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (done || err));

  a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdGnt) |=> (rdReq && $stable(rdAddr)));

  a_r5_wr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrGnt) |=> (wrReq && $stable(wrAddr)));

endmodule

bind xferEngine xferChecker #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .ADDR_W     (ADDR_W)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .regWe   (regWe),
  .regAddr (regAddr),
  .rdReq   (rdReq),
  .rdAddr  (rdAddr),
  .rdGnt   (rdGnt),
  .rdValid (rdValid),
  .rdErr   (rdErr),
  .wrReq   (wrReq),
  .wrAddr  (wrAddr),
  .wrGnt   (wrGnt),
  .wrAck   (wrAck),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .irq     (irq)
);

// File: tb/xferEngine_tb_top.sv
module xferEngine_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic        rdReq, wrReq, irq;
  logic [31:0] rdAddr, wrAddr, wrData;
  logic        rdGnt = 1'b0, rdValid = 1'b0, rdErr = 1'b0;
  logic [31:0] rdData = 32'd0;
  logic        wrGnt = 1'b0, wrAck = 1'b0, wrErr = 1'b0;

  int checks = 0;
  int errors = 0;

  // current copy description
  logic [31:0] curSrc, curDst;
  bit          curSInc, curDInc;
  int          rdSeq, wrSeq, acks, rdErrAt, wrErrAt;
  int          occ, peak;
  int          rdGntMax, rdLatMax, wrGntMax, wrLatMax;

  always #2 clk = ~clk;

  xferEngine #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .rdReq(rdReq), .rdAddr(rdAddr), .rdGnt(rdGnt),
    .rdValid(rdValid), .rdData(rdData), .rdErr(rdErr), .wrReq(wrReq),
    .wrAddr(wrAddr), .wrData(wrData), .wrGnt(wrGnt), .wrAck(wrAck),
    .wrErr(wrErr), .irq(irq)
  );

  function automatic logic [31:0] wordOf(input logic [31:0] a, input int k);
    return (a * 32'h9E3779B1) ^ (32'(k) * 32'h85EBCA6B) ^ 32'h0F1E2D3C;
  endfunction

  function automatic logic [31:0] expSrc(input int k);
    return curSrc + (curSInc ? 32'(4 * k) : 32'd0);
  endfunction

  function automatic logic [31:0] expDst(input int k);
    return curDst + (curDInc ? 32'(4 * k) : 32'd0);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  // source side responder
  initial begin : rdResponder
    logic [31:0] a;
    forever begin
      @(negedge clk);
      rdGnt = 1'b0; rdValid = 1'b0; rdErr = 1'b0;
      if (rdReq) begin
        repeat ($urandom_range(rdGntMax, 0)) @(negedge clk);
        rdGnt = 1'b1;
        a = rdAddr;
        check(a == expSrc(rdSeq), "R4 read address", a, expSrc(rdSeq));
        @(negedge clk);
        rdGnt = 1'b0;
        repeat ($urandom_range(rdLatMax, 0)) @(negedge clk);
        rdValid = 1'b1;
        rdData = wordOf(a, rdSeq);
        rdErr = (rdSeq == rdErrAt);
        rdSeq++;
      end
    end
  end

  // destination side responder
  initial begin : wrResponder
    int k;
    forever begin
      @(negedge clk);
      wrGnt = 1'b0; wrAck = 1'b0; wrErr = 1'b0;
      if (wrReq) begin
        repeat ($urandom_range(wrGntMax, 0)) @(negedge clk);
        wrGnt = 1'b1;
        k = wrSeq;
        check(wrAddr == expDst(k), "R5 write address", wrAddr, expDst(k));
        check(wrData == wordOf(expSrc(k), k), "R6 write data", wrData, wordOf(expSrc(k), k));
        wrSeq++;
        @(negedge clk);
        wrGnt = 1'b0;
        repeat ($urandom_range(wrLatMax, 0)) @(negedge clk);
        wrAck = 1'b1;
        wrErr = (k == wrErrAt);
        acks++;
      end
    end
  end

  // FIFO occupancy seen from the ports
  always @(posedge clk) begin
    if (rdValid && !rdErr) occ = occ + 1;
    if (wrGnt) occ = occ - 1;
    if (occ > peak) peak = occ;
  end

  task automatic setDelays(input int rg, input int rl, input int wg, input int wl);
    rdGntMax = rg; rdLatMax = rl; wrGntMax = wg; wrLatMax = wl;
  endtask

  task automatic runXfer(input logic [31:0] src, input logic [31:0] dst, input int words,
                         input bit sInc, input bit dInc, input bit ien,
                         input int rdE, input int wrE, input bit meddle);
    logic [31:0] s, v;
    bit earlyDone;
    int polls;
    curSrc = src; curDst = dst; curSInc = sInc; curDInc = dInc;
    rdSeq = 0; wrSeq = 0; acks = 0; occ = 0; peak = 0;
    rdErrAt = rdE; wrErrAt = wrE;
    earlyDone = 1'b0;
    regWrite(3'd0, src);
    regWrite(3'd1, dst);
    regWrite(3'd2, {29'd0, ien, dInc, sInc});
    regWrite(3'd3, 32'(words * 4));
    if (meddle) begin
      regWrite(3'd0, ~src);
      regWrite(3'd1, ~dst);
      regWrite(3'd2, {29'd0, ~ien, ~dInc, ~sInc});
      regWrite(3'd3, 32'd8);
    end
    polls = 0;
    s = 32'd1;
    while (s[0] && polls < 20000) begin
      regRead(3'd4, s);
      if (s[1] && s[0]) earlyDone = 1'b1;
      if (s[1] && !s[0] && acks != words) earlyDone = 1'b1;
      polls++;
    end
    check(!s[0], "R3 copy ends (busy clears)", s, 32'd0);
    if (rdE < 0 && wrE < 0) begin
      check(s[2:0] == 3'b010, "R3/R8 status done, error cleared", s, 32'd2);
      check(!earlyDone, "R8 done only on last ack", acks, words);
      check(wrSeq == words && rdSeq == words, "R6 word count", wrSeq, words);
      check(peak <= DEPTH, "R7 occupancy bound", peak, DEPTH);
      #1 check(irq == ien, "R12 irq on done", irq, ien);
      regRead(3'd3, v);
      check(v == 32'(words * 4), "R2 length readback", v, words * 4);
      if (meddle) begin
        regRead(3'd0, v);
        check(v == src, "R11 source reg kept", v, src);
        regRead(3'd2, v);
        check(v == {29'd0, ien, dInc, sInc}, "R11 mode reg kept", v, {29'd0, ien, dInc, sInc});
      end
      regWrite(3'd4, 32'd2);
      regRead(3'd4, v);
      check(v[1] == 1'b0, "R9 done cleared by write", v, 32'd0);
      check(irq == 1'b0, "R12 irq drops", irq, 32'd0);
    end else begin
      check(s[2:0] == 3'b100, "R10 error status", s, 32'd4);
      #1 check(irq == ien, "R12 irq on error", irq, ien);
      repeat (20) @(negedge clk);
      check(!rdReq && !wrReq, "R10 no requests after error", {rdReq, wrReq}, 32'd0);
      if (rdE >= 0) check(wrSeq <= rdE, "R10 writes stop at read error", wrSeq, rdE);
      if (wrE >= 0) check(wrSeq == wrE + 1, "R10 writes stop at write error", wrSeq, wrE + 1);
    end
    repeat (20) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : mainSeq
    logic [31:0] v;
    void'($urandom(32'd20240611));
    setDelays(1, 1, 1, 1);
    rdErrAt = -1; wrErrAt = -1; rdSeq = 0; wrSeq = 0; acks = 0;
    curSrc = 0; curDst = 0; curSInc = 1; curDInc = 1;
    occ = 0; peak = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(3'd4, v);
    check(v == 32'd0, "R1 status after reset", v, 32'd0);
    check(!irq && !rdReq && !wrReq, "R1 outputs after reset", {irq, rdReq, wrReq}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      regRead(3'(i), v);
      check(v == 32'd0, "R1 register after reset", v, 32'd0);
    end

    // R2 readback, R3 ignored start with only low bits
    regWrite(3'd0, 32'h1000_0040);
    regRead(3'd0, v);
    check(v == 32'h1000_0040, "R2 source readback", v, 32'h1000_0040);
    regWrite(3'd1, 32'h2000_0080);
    regRead(3'd1, v);
    check(v == 32'h2000_0080, "R2 destination readback", v, 32'h2000_0080);
    regWrite(3'd2, 32'h0000_0005);
    regRead(3'd2, v);
    check(v == 32'h5, "R2 mode readback", v, 32'h5);
    regWrite(3'd3, 32'd3);
    regRead(3'd4, v);
    check(v[0] == 1'b0, "R3 low-bit length does not start", v, 32'd0);
    regRead(3'd3, v);
    check(v == 32'd0, "R2 length low bits read zero", v, 32'd0);

    // directed copies over all step combinations
    runXfer(32'h1000_0000, 32'h2000_0000, 8, 1, 1, 1, -1, -1, 0);
    runXfer(32'h3000_0010, 32'h2000_0100, 6, 0, 1, 0, -1, -1, 0);  // R4 fixed source
    runXfer(32'h1000_0200, 32'h4000_0020, 6, 1, 0, 1, -1, -1, 0);  // R5 fixed destination
    runXfer(32'h3000_0010, 32'h4000_0020, 5, 0, 0, 0, -1, -1, 0);
    runXfer(32'h1000_0300, 32'h2000_0300, 1, 1, 1, 1, -1, -1, 0);  // single word

    // R7 slow destination fills the FIFO to its depth
    setDelays(0, 0, 6, 6);
    runXfer(32'h1100_0000, 32'h2100_0000, 64, 1, 1, 0, -1, -1, 0);
    check(peak == DEPTH, "R7 FIFO fills to depth", peak, DEPTH);
    // fast destination: both channels active together
    setDelays(3, 3, 0, 0);
    runXfer(32'h1200_0000, 32'h2200_0000, 24, 1, 1, 0, -1, -1, 0);

    // R11 register writes while busy
    setDelays(2, 2, 2, 2);
    runXfer(32'h1300_0000, 32'h2300_0000, 32, 1, 1, 0, -1, -1, 1);

    // R10 errors
    setDelays(1, 1, 1, 1);
    runXfer(32'h1400_0000, 32'h2400_0000, 12, 1, 1, 1, 5, -1, 0);
    regWrite(3'd4, 32'd4);
    regRead(3'd4, v);
    check(v[2] == 1'b0, "R9 error cleared by write", v, 32'd0);
    #1 check(irq == 1'b0, "R12 irq drops after error clear", irq, 32'd0);
    runXfer(32'h1500_0000, 32'h2500_0000, 12, 1, 0, 0, -1, 3, 0);
    // R3 new start clears the error left behind
    runXfer(32'h1600_0000, 32'h2600_0000, 4, 1, 1, 0, -1, -1, 0);

    // randomized copies
    for (int t = 0; t < 20; t++) begin
      setDelays($urandom_range(3, 0), $urandom_range(3, 0), $urandom_range(3, 0), $urandom_range(3, 0));
      runXfer($urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC, $urandom_range(40, 1),
              1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
              -1, -1, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule